// File: doc/BRIEF.md
# Circular Queue Pointer Manager

This block keeps the producer and consumer pointers of a circular queue of fixed-size entries held in memory, such as the command or event queue of an I/O address translation unit. It holds the queue base address, a programmable log2 entry count, the two pointer registers and a small control register. From these it derives the full and empty flags and the byte addresses of the entries the two pointers currently select.

Each pointer is an index plus one wrap flag just above it. A one-cycle strobe advances either pointer by a single entry. A separate port records an error code in a field of the consumer register, and that field survives consumer advances. Memory traffic, command decoding and interrupts are handled elsewhere. A parameter sets the entry size (16 bytes for commands, 32 for events). A second parameter picks which control bit enables the queue.

Top module: `cq_ptr_mgr`

## Requirements
- R1: Each pointer keeps its index in bits [L-1:0], where L is the log2 size, and its wrap flag in bit L. An advance from index 2^L-1 goes to index 0 and toggles the wrap flag.
- R2: `full` is 1 when the low L+1 bits of the two pointers XOR to exactly 1<<L, that is equal indices with different wrap flags. Bits above L have no effect on it.
- R3: `empty` is 1 when bits [L:0] of the producer and the consumer are identical.
- R4: A producer advance gives (prod+1) masked to bits [L:0], so every producer bit above L becomes 0.
- R5: A consumer advance changes only bits [L:0], to the low L+1 bits of cons+1. All higher bits, including the error field, are kept.
- R6: An error write (`err_wr`) puts `err_code` into consumer bits [30:24] on the next clock. The codes are 0 none, 1 illegal command, 2 abort, 3 invalidate-sync failure. A consumer advance in the same cycle is applied as well. A software write to the consumer register in the same cycle wins over the error write.
- R7: The stored base is the written value ANDed with 0xFFFF_FFFF_FFE0. Each entry address is the base plus ENTRY_BYTES times that pointer's index (bits [L-1:0]).
- R8: Control bit 3 enables a command queue (IS_CMDQ=1) and bit 2 enables an event queue. Bit 0 is the global enable and does not gate the pointers. While the queue's own enable bit is 0, advance strobes are ignored.
- R9: A write with `wr_en` takes effect on the next clock. `wr_sel` selects the register: 0 base, 1 log2 size, 2 producer, 3 consumer, 4 control. Other codes do nothing. A pointer write in the same cycle as that pointer's advance wins.
- R10: A log2 size write below 1 stores 1, and a write above MAX_LOG2 (default 19) stores MAX_LOG2.
- R11: After reset both pointers, the base and the control register are 0, the log2 size is 1, `empty` is 1 and `full` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for the write |
| wr_data | input | ADDR_W | Write data (pointers use bits [31:0]) |
| prod_inc | input | 1 | Advance the producer by one entry |
| cons_inc | input | 1 | Advance the consumer by one entry |
| err_wr | input | 1 | Record an error code in the consumer register |
| err_code | input | 7 | Error code to record |
| base_q | output | ADDR_W | Aligned base address |
| log2_q | output | LOG2_W | Current log2 size |
| ctrl_q | output | 4 | Control register |
| q_enabled | output | 1 | Queue enable bit selected by IS_CMDQ |
| prod_q | output | 32 | Producer register |
| cons_q | output | 32 | Consumer register |
| full | output | 1 | Queue full |
| empty | output | 1 | Queue empty |
| prod_addr | output | ADDR_W | Byte address of the producer entry |
| cons_addr | output | ADDR_W | Byte address of the consumer entry |

## Verification
The pointer assertions measure masks against the log2 size of the previous cycle. They therefore assume the size is not rewritten in the same cycle as an advance. The bench always changes the size in a cycle of its own, with no strobe active. Most scenarios run with the queue enabled. The bench clears the enable bit only to exercise the ignored-strobe case. All inputs change on the falling edge, away from the edge that updates the registers.

// File: rtl/cqp_pkg.sv
package cqp_pkg;
    localparam int PTR_W    = 32;
    localparam int ERR_LSB  = 24;
    localparam int ERR_W    = 7;
    localparam int CTRL_W   = 4;
    localparam int GLOBAL_EN_BIT = 0;
    localparam int EVTQ_EN_BIT   = 2;
    localparam int CMDQ_EN_BIT   = 3;

    typedef logic [PTR_W-1:0] ptr_t;

    typedef enum logic [2:0] {
        SEL_BASE = 3'd0,
        SEL_LOG2 = 3'd1,
        SEL_PROD = 3'd2,
        SEL_CONS = 3'd3,
        SEL_CTRL = 3'd4
    } reg_sel_e;

    typedef enum logic [ERR_W-1:0] {
        ERR_NONE    = 7'd0,
        ERR_ILLEGAL = 7'd1,
        ERR_ABORT   = 7'd2,
        ERR_SYNC    = 7'd3
    } err_code_e;

    // mask of index plus wrap flag: bits [l2:0]
    function automatic ptr_t wrap_idx_mask(input int unsigned l2);
        return (ptr_t'(1) << (l2 + 1)) - ptr_t'(1);
    endfunction

    function automatic ptr_t idx_mask(input int unsigned l2);
        return (ptr_t'(1) << l2) - ptr_t'(1);
    endfunction

    function automatic logic q_full(input ptr_t p, input ptr_t c, input int unsigned l2);
        return ((p ^ c) & wrap_idx_mask(l2)) == (ptr_t'(1) << l2);
    endfunction

    function automatic logic q_empty(input ptr_t p, input ptr_t c, input int unsigned l2);
        return ((p ^ c) & wrap_idx_mask(l2)) == ptr_t'(0);
    endfunction

    // advance that clears everything above the wrap flag
    function automatic ptr_t adv_masked(input ptr_t q, input int unsigned l2);
        return (q + ptr_t'(1)) & wrap_idx_mask(l2);
    endfunction

    // advance that deposits into bits [l2:0] and keeps the rest
    function automatic ptr_t adv_deposit(input ptr_t q, input int unsigned l2);
        return (q & ~wrap_idx_mask(l2)) | ((q + ptr_t'(1)) & wrap_idx_mask(l2));
    endfunction
endpackage

// File: rtl/cq_cfg_regs.sv
module cq_cfg_regs
    import cqp_pkg::*;
#(
    parameter int ADDR_W    = 48,
    parameter int BASE_LSB  = 5,
    parameter int MAX_LOG2  = 19,
    parameter bit IS_CMDQ   = 1'b1,
    localparam int LOG2_W   = $clog2(MAX_LOG2 + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  reg_sel_e          wr_sel_i,
    input  logic [ADDR_W-1:0] wr_data_i,
    output logic [ADDR_W-1:0] base_o,
    output logic [LOG2_W-1:0] log2_o,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic              q_en_o
);
    localparam logic [ADDR_W-1:0] BASE_MASK = ~((ADDR_W'(1) << BASE_LSB) - ADDR_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            base_o <= '0;
            log2_o <= LOG2_W'(1);
            ctrl_o <= '0;
        end else if (wr_en_i) begin
            case (wr_sel_i)
                SEL_BASE: base_o <= wr_data_i & BASE_MASK;
                SEL_LOG2: begin
                    if (wr_data_i < ADDR_W'(1))
                        log2_o <= LOG2_W'(1);
                    else if (wr_data_i > ADDR_W'(MAX_LOG2))
                        log2_o <= LOG2_W'(MAX_LOG2);
                    else
                        log2_o <= LOG2_W'(wr_data_i);
                end
                SEL_CTRL: ctrl_o <= wr_data_i[CTRL_W-1:0];
                default: ;
            endcase
        end
    end

    generate
        if (IS_CMDQ) begin : g_cmdq
            assign q_en_o = ctrl_o[CMDQ_EN_BIT];
        end else begin : g_evtq
            assign q_en_o = ctrl_o[EVTQ_EN_BIT];
        end
    endgenerate

    AST_LOG2_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (log2_o >= LOG2_W'(1)) && (log2_o <= LOG2_W'(MAX_LOG2))); // R10
    AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        wr_en_i && wr_sel_i == SEL_BASE |=> base_o[BASE_LSB-1:0] == '0); // R7
endmodule

// File: rtl/cq_ptr_reg.sv
module cq_ptr_reg
    import cqp_pkg::*;
#(
    parameter bit PRESERVE_UPPER = 1'b0,
    parameter int MAX_LOG2       = 19,
    localparam int LOG2_W        = $clog2(MAX_LOG2 + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic              inc_i,
    input  logic              wr_i,
    input  ptr_t              wr_data_i,
    input  logic [LOG2_W-1:0] log2_i,
    input  logic              err_wr_i,
    input  logic [ERR_W-1:0]  err_code_i,
    output ptr_t              q_o
);
    ptr_t adv_val;
    ptr_t nxt;

    generate
        if (PRESERVE_UPPER) begin : g_deposit
            assign adv_val = adv_deposit(q_o, 32'(log2_i));
        end else begin : g_masked
            assign adv_val = adv_masked(q_o, 32'(log2_i));
        end
    endgenerate

    always_comb begin
        nxt = q_o;
        if (wr_i) begin
            nxt = wr_data_i;
        end else begin
            if (en_i && inc_i) nxt = adv_val;
            if (err_wr_i) nxt[ERR_LSB +: ERR_W] = err_code_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q_o <= '0;
        else     q_o <= nxt;
    end

    generate
        if (PRESERVE_UPPER) begin : g_chk_keep
            AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (rst)
                !wr_i && !err_wr_i && en_i && inc_i |=>
                (q_o & ~wrap_idx_mask(32'($past(log2_i)))) ==
                ($past(q_o) & ~wrap_idx_mask(32'($past(log2_i))))); // R5
        end else begin : g_chk_clear
            AST_UPPER_CLEARED: assert property (@(posedge clk) disable iff (rst)
                !wr_i && !err_wr_i && en_i && inc_i |=>
                (q_o & ~wrap_idx_mask(32'($past(log2_i)))) == '0); // R4
        end
    endgenerate

    AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_i && !err_wr_i && !en_i |=> $stable(q_o)); // R8
    AST_ERR_RECORDED: assert property (@(posedge clk) disable iff (rst)
        !wr_i && err_wr_i |=> q_o[ERR_LSB +: ERR_W] == $past(err_code_i)); // R6
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        wr_i |=> q_o == $past(wr_data_i)); // R9
endmodule

// File: rtl/cq_status.sv
module cq_status
    import cqp_pkg::*;
#(
    parameter int ADDR_W      = 48,
    parameter int ENTRY_BYTES = 16,
    parameter int MAX_LOG2    = 19,
    localparam int LOG2_W     = $clog2(MAX_LOG2 + 1),
    localparam int ENTRY_SHIFT = $clog2(ENTRY_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  ptr_t              prod_i,
    input  ptr_t              cons_i,
    input  logic [LOG2_W-1:0] log2_i,
    input  logic [ADDR_W-1:0] base_i,
    output logic              full_o,
    output logic              empty_o,
    output logic [ADDR_W-1:0] prod_addr_o,
    output logic [ADDR_W-1:0] cons_addr_o
);
    ptr_t prod_idx;
    ptr_t cons_idx;

    assign full_o   = q_full(prod_i, cons_i, 32'(log2_i));
    assign empty_o  = q_empty(prod_i, cons_i, 32'(log2_i));
    assign prod_idx = prod_i & idx_mask(32'(log2_i));
    assign cons_idx = cons_i & idx_mask(32'(log2_i));

    assign prod_addr_o = base_i + (ADDR_W'(prod_idx) << ENTRY_SHIFT);
    assign cons_addr_o = base_i + (ADDR_W'(cons_idx) << ENTRY_SHIFT);

    AST_FULL_NOT_EMPTY: assert property (@(posedge clk) disable iff (rst)
        !(full_o && empty_o)); // R2
endmodule

// File: rtl/cq_ptr_mgr.sv
module cq_ptr_mgr
    import cqp_pkg::*;
#(
    parameter int ADDR_W      = 48,
    parameter int ENTRY_BYTES = 16,
    parameter int MAX_LOG2    = 19,
    parameter bit IS_CMDQ     = 1'b1,
    localparam int LOG2_W     = $clog2(MAX_LOG2 + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              prod_inc,
    input  logic              cons_inc,
    input  logic              err_wr,
    input  logic [6:0]        err_code,
    output logic [ADDR_W-1:0] base_q,
    output logic [LOG2_W-1:0] log2_q,
    output logic [3:0]        ctrl_q,
    output logic              q_enabled,
    output logic [31:0]       prod_q,
    output logic [31:0]       cons_q,
    output logic              full,
    output logic              empty,
    output logic [ADDR_W-1:0] prod_addr,
    output logic [ADDR_W-1:0] cons_addr
);
    reg_sel_e sel;
    logic     prod_wr;
    logic     cons_wr;

    assign sel     = reg_sel_e'(wr_sel);
    assign prod_wr = wr_en && (sel == SEL_PROD);
    assign cons_wr = wr_en && (sel == SEL_CONS);

    cq_cfg_regs #(
        .ADDR_W(ADDR_W), .BASE_LSB(5), .MAX_LOG2(MAX_LOG2), .IS_CMDQ(IS_CMDQ)
    ) u_cfg (
        .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_sel_i(sel), .wr_data_i(wr_data),
        .base_o(base_q), .log2_o(log2_q), .ctrl_o(ctrl_q), .q_en_o(q_enabled)
    );

    cq_ptr_reg #(.PRESERVE_UPPER(1'b0), .MAX_LOG2(MAX_LOG2)) u_prod (
        .clk(clk), .rst(rst), .en_i(q_enabled), .inc_i(prod_inc), .wr_i(prod_wr),
        .wr_data_i(wr_data[PTR_W-1:0]), .log2_i(log2_q), .err_wr_i(1'b0),
        .err_code_i('0), .q_o(prod_q)
    );

    cq_ptr_reg #(.PRESERVE_UPPER(1'b1), .MAX_LOG2(MAX_LOG2)) u_cons (
        .clk(clk), .rst(rst), .en_i(q_enabled), .inc_i(cons_inc), .wr_i(cons_wr),
        .wr_data_i(wr_data[PTR_W-1:0]), .log2_i(log2_q), .err_wr_i(err_wr),
        .err_code_i(err_code), .q_o(cons_q)
    );

    cq_status #(
        .ADDR_W(ADDR_W), .ENTRY_BYTES(ENTRY_BYTES), .MAX_LOG2(MAX_LOG2)
    ) u_stat (
        .clk(clk), .rst(rst), .prod_i(prod_q), .cons_i(cons_q), .log2_i(log2_q),
        .base_i(base_q), .full_o(full), .empty_o(empty),
        .prod_addr_o(prod_addr), .cons_addr_o(cons_addr)
    );
endmodule

// File: tb/cq_ptr_mgr_tb_top.sv
module cq_ptr_mgr_tb_top;
    localparam int ADDR_W = 48;
    localparam logic [47:0] BASE_IN  = 48'h1234_5678_9ABF;
    localparam logic [47:0] BASE_EXP = 48'h1234_5678_9AA0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [47:0] wr_data = '0;
    logic        prod_inc = 1'b0;
    logic        cons_inc = 1'b0;
    logic        err_wr = 1'b0;
    logic [6:0]  err_code = '0;
    logic [47:0] base_q;
    logic [4:0]  log2_q;
    logic [3:0]  ctrl_q;
    logic        q_enabled;
    logic [31:0] prod_q;
    logic [31:0] cons_q;
    logic        full;
    logic        empty;
    logic [47:0] prod_addr;
    logic [47:0] cons_addr;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    cq_ptr_mgr dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .prod_inc(prod_inc), .cons_inc(cons_inc), .err_wr(err_wr), .err_code(err_code),
        .base_q(base_q), .log2_q(log2_q), .ctrl_q(ctrl_q), .q_enabled(q_enabled),
        .prod_q(prod_q), .cons_q(cons_q), .full(full), .empty(empty),
        .prod_addr(prod_addr), .cons_addr(cons_addr)
    );

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    // one clock: inputs set after a falling edge, sampled at the next one
    task automatic step();
        @(negedge clk);
        wr_en = 1'b0; prod_inc = 1'b0; cons_inc = 1'b0; err_wr = 1'b0;
    endtask

    task automatic wreg(input logic [2:0] sel, input logic [47:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        step();
    endtask

    task automatic setup(input int l2);
        wreg(3'd1, 48'(l2));
        wreg(3'd0, BASE_IN);
        wreg(3'd4, 48'h8);
        wreg(3'd2, 48'h0);
        wreg(3'd3, 48'h0);
    endtask

    task automatic t_reset();
        chk("R11 prod", 64'(prod_q), 0);
        chk("R11 cons", 64'(cons_q), 0);
        chk("R11 log2", 64'(log2_q), 1);
        chk("R11 ctrl", 64'(ctrl_q), 0);
        chk("R11 empty", 64'(empty), 1);
        chk("R11 full", 64'(full), 0);
    endtask

    task automatic t_fill();
        setup(2);
        chk("R7 base mask", 64'(base_q), 64'(BASE_EXP));
        chk("R3 empty at start", 64'(empty), 1);
        prod_inc = 1'b1; step();
        chk("R4 prod after one", 64'(prod_q), 1);
        chk("R7 prod addr", 64'(prod_addr), 64'(BASE_EXP + 48'd16));
        chk("R3 not empty", 64'(empty), 0);
        for (int i = 0; i < 3; i++) begin prod_inc = 1'b1; step(); end
        chk("R1 prod wrap flag", 64'(prod_q), 4);
        chk("R2 full", 64'(full), 1);
        chk("R7 prod addr wrapped", 64'(prod_addr), 64'(BASE_EXP));
        wreg(3'd3, 48'h0300_0000);
        chk("R2 full ignores err field", 64'(full), 1);
    endtask

    task automatic t_drain();
        wreg(3'd3, 48'h0);
        cons_inc = 1'b1; step();
        chk("R7 cons addr", 64'(cons_addr), 64'(BASE_EXP + 48'd16));
        for (int i = 0; i < 3; i++) begin cons_inc = 1'b1; step(); end
        chk("R5 cons after four", 64'(cons_q), 4);
        chk("R3 empty after drain", 64'(empty), 1);
        chk("R2 not full after drain", 64'(full), 0);
    endtask

    task automatic t_upper();
        wreg(3'd2, 48'hFFFF_FF03);
        prod_inc = 1'b1; step();
        chk("R4 prod upper cleared", 64'(prod_q), 4);
        wreg(3'd3, 48'h4500_0007);
        cons_inc = 1'b1; step();
        chk("R5 cons upper kept, wrap toggles", 64'(cons_q), 64'h4500_0000);
    endtask

    task automatic t_err();
        err_wr = 1'b1; err_code = 7'd2; step();
        chk("R6 abort code", 64'(cons_q), 64'h0200_0000);
        err_wr = 1'b1; err_code = 7'd1; cons_inc = 1'b1; step();
        chk("R6 err with advance", 64'(cons_q), 64'h0100_0001);
        wr_en = 1'b1; wr_sel = 3'd3; wr_data = 48'h5;
        err_wr = 1'b1; err_code = 7'd3; step();
        chk("R6 sw write beats err", 64'(cons_q), 5);
    endtask

    task automatic t_disabled();
        wreg(3'd2, 48'h1);
        wreg(3'd4, 48'h4);
        chk("R8 event bit not ours", 64'(q_enabled), 0);
        prod_inc = 1'b1; step();
        chk("R8 ignored with bit2", 64'(prod_q), 1);
        wreg(3'd4, 48'h1);
        cons_inc = 1'b1; prod_inc = 1'b1; step();
        chk("R8 ignored with bit0", 64'(prod_q), 1);
        chk("R8 cons ignored", 64'(cons_q), 5);
        wreg(3'd4, 48'h8);
        chk("R8 enabled", 64'(q_enabled), 1);
    endtask

    task automatic t_priority();
        wr_en = 1'b1; wr_sel = 3'd2; wr_data = 48'h6; prod_inc = 1'b1; step();
        chk("R9 write beats advance", 64'(prod_q), 6);
        wreg(3'd7, 48'hFFFF);
        chk("R9 unused select prod", 64'(prod_q), 6);
        chk("R9 unused select base", 64'(base_q), 64'(BASE_EXP));
    endtask

    task automatic t_clamp();
        wreg(3'd1, 48'd0);
        chk("R10 clamp low", 64'(log2_q), 1);
        wreg(3'd1, 48'd25);
        chk("R10 clamp high", 64'(log2_q), 19);
    endtask

    task automatic t_large();
        wreg(3'd2, 48'h8_0000);
        wreg(3'd3, 48'h0);
        chk("R2 full at max size", 64'(full), 1);
        wreg(3'd2, 48'h8_0005);
        chk("R7 addr at max size", 64'(prod_addr), 64'(BASE_EXP + 48'h50));
        wreg(3'd2, 48'hF_FFFF);
        prod_inc = 1'b1; step();
        chk("R1 wrap flag toggles back", 64'(prod_q), 0);
        chk("R3 empty again", 64'(empty), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_fill();
        t_drain();
        t_upper();
        t_err();
        t_disabled();
        t_priority();
        t_clamp();
        t_large();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule